// File: doc/BRIEF.md
# Lockstep Step Controller for a Hardware Model Under Co-Simulation

This block lets a host-side software simulation advance a piece of hardware (the model under test) in lockstep with its own time steps. It owns the clock enable of that model. The host loads a step length and a cycle budget through write strobes, then pulses a start input. The block enables the model either for a fixed number of cycles or, when the step length is zero, until the model reports completion on a handshake input.

A busy output stays high while the model is enabled, so the host does not change the model's inputs during a step. If a step does not finish within the cycle budget, the block stops enabling the model. It then raises an overrun flag, which stays set until the host clears it. While the flag is set the block refuses new steps.

Top module: `ccs_step_sync`

## Requirements
- R1: While reset is asserted, and after it is released with no further stimulus, `dut_en_o`, `busy_o` and `overrun_o` are low, and both configuration registers hold zero.
- R2: A pulse on `run_wr_i` loads `wdata_i` into the step-length register, and a pulse on `lim_wr_i` loads it into the cycle-budget register. A write made while `busy_o` is high is ignored.
- R3: A start pulse accepted with a nonzero step length N drives `dut_en_o` high for exactly N consecutive cycles. The first of these begins on the clock edge that samples the start pulse. After the last one, `dut_en_o` goes low.
- R4: A start pulse accepted with a step length of zero keeps `dut_en_o` high from the clock edge that samples the start. The enabled cycle in which `dut_done_i` is sampled high is the last one.
- R5: `busy_o` is high in exactly the cycles in which `dut_en_o` is high.
- R6: `dut_done_i` has no effect during a fixed-length step or while the block is idle.
- R7: For a nonzero budget L, a step that has not finished after L enabled cycles ends after exactly L enabled cycles, and `overrun_o` rises. A step that finishes in its L-th cycle or earlier sets no overrun. This holds in both modes. A budget of zero disables the check.
- R8: `overrun_o` stays high until `ovr_clr_i` is pulsed, and clearing returns the block to idle. A clear pulse while `overrun_o` is low has no effect.
- R9: A start pulse while `overrun_o` is high is ignored: `dut_en_o` stays low and `overrun_o` stays high.
- R10: A start pulse while `busy_o` is high is ignored and neither restarts nor lengthens the current step.
- R11: A step length of one enables the model for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the model under test |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wdata_i | input | CNT_W | Write data for the configuration registers |
| run_wr_i | input | 1 | Write strobe for the step-length register (0 = open-ended) |
| lim_wr_i | input | 1 | Write strobe for the cycle-budget register (0 = unlimited) |
| start_i | input | 1 | Start-of-step pulse |
| ovr_clr_i | input | 1 | Clear strobe for the overrun flag |
| dut_done_i | input | 1 | Completion handshake from the model (open-ended steps) |
| dut_en_o | output | 1 | Clock enable for the model under test |
| busy_o | output | 1 | Step in progress |
| overrun_o | output | 1 | Sticky cycle-budget violation flag |

## Verification
The bench goes after off-by-one step lengths. A design that compares the counter against N instead of N-1 would enable a one-cycle step for two cycles. The bench also probes the case where completion and budget expiry fall in the same cycle. Completion must win there, and a design that gives priority the other way would report an overrun on a step that ended in time. Starts and register writes made during a step are checked as well. Acting on them would restart the counter or stretch the step. Starts and clears around an overrun are tested too, since a flag that is not sticky, or a start that slips through during an overrun, would show up on `overrun_o` and `dut_en_o`.

// File: rtl/ccs_pkg.sv
package ccs_pkg;

  // Step controller states; encoding is free, nothing outside decodes it.
  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_RUN_PER  = 2'd1,
    ST_RUN_APER = 2'd2,
    ST_OVERRUN  = 2'd3
  } ccs_state_e;

endpackage

// File: rtl/ccs_rst_sync.sv
module ccs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/ccs_cfg_regs.sv
module ccs_cfg_regs #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busy_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             run_wr_i,
  input  logic             lim_wr_i,
  output logic [CNT_W-1:0] run_len_o,
  output logic [CNT_W-1:0] lim_o
);

  logic             run_ce;
  logic             lim_ce;
  logic [CNT_W-1:0] run_q;
  logic [CNT_W-1:0] lim_q;

  // Host writes only land between steps.
  assign run_ce = run_wr_i && !busy_i;
  assign lim_ce = lim_wr_i && !busy_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (run_ce) begin
      run_q <= wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lim_q <= '0;
    end else if (lim_ce) begin
      lim_q <= wdata_i;
    end
  end

  assign run_len_o = run_q;
  assign lim_o     = lim_q;

  // R2: configuration cannot move under a running step
  a_r2_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |=> ($stable(run_q) && $stable(lim_q)));

endmodule

// File: rtl/ccs_step_counter.sv
module ccs_step_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [CNT_W-1:0] run_len_i,
  input  logic [CNT_W-1:0] lim_i,
  output logic             last_run_o,
  output logic             last_lim_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ONE     = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_ce;

  // Enabled cycles already completed in the current step; saturates so an
  // unlimited open-ended step never wraps back to zero.
  always_comb begin
    cnt_ce = clr_i || (en_i && (cnt_q != CNT_MAX));
    if (clr_i) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_ce) begin
      cnt_q <= cnt_d;
    end
  end

  // Current cycle is the final one of a fixed-length step / of the budget.
  assign last_run_o = (cnt_q == (run_len_i - ONE));
  assign last_lim_o = (lim_i != '0) && (cnt_q == (lim_i - ONE));

  // R7: an enabled cycle never lies beyond the cycle budget
  a_r7_within_budget: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && (lim_i != '0)) |-> (cnt_q < lim_i));

  // R3: a fixed-length step never enables beyond its length
  a_r3_within_length: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && (run_len_i != '0)) |-> (cnt_q < run_len_i));

  // R10: once enabled, the count only moves forward (no restart mid-step)
  a_r10_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    en_i |=> (cnt_q != '0));

endmodule

// File: rtl/ccs_ctrl_fsm.sv
module ccs_ctrl_fsm
  import ccs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic ovr_clr_i,
  input  logic dut_done_i,
  input  logic run_nz_i,
  input  logic last_run_i,
  input  logic last_lim_i,
  output logic cnt_clr_o,
  output logic dut_en_o,
  output logic busy_o,
  output logic overrun_o
);

  ccs_state_e state_q;
  ccs_state_e state_d;

  always_comb begin
    state_d   = state_q;
    cnt_clr_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          cnt_clr_o = 1'b1;
          state_d   = run_nz_i ? ST_RUN_PER : ST_RUN_APER;
        end
      end
      ST_RUN_PER: begin
        if (last_run_i) begin
          state_d = ST_IDLE;
        end else if (last_lim_i) begin
          state_d = ST_OVERRUN;
        end
      end
      ST_RUN_APER: begin
        // completion in the final budget cycle still counts as on time
        if (dut_done_i) begin
          state_d = ST_IDLE;
        end else if (last_lim_i) begin
          state_d = ST_OVERRUN;
        end
      end
      ST_OVERRUN: begin
        if (ovr_clr_i) begin
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  assign dut_en_o  = (state_q == ST_RUN_PER) || (state_q == ST_RUN_APER);
  assign busy_o    = dut_en_o;
  assign overrun_o = (state_q == ST_OVERRUN);

  // R8: overrun flag holds until the host clears it
  a_r8_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun_o && !ovr_clr_i) |=> overrun_o);

  // R7: the model is never enabled while an overrun is flagged
  a_r7_ovr_disables: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_o |-> !dut_en_o);

  // R4: handshake during an open-ended step ends it on that edge
  a_r4_done_ends: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_RUN_APER) && dut_done_i) |=> (state_q == ST_IDLE));

  // R9: a start during overrun does not launch a step
  a_r9_start_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun_o && start_i && !ovr_clr_i) |=> !dut_en_o);

endmodule

// File: rtl/ccs_step_sync.sv
module ccs_step_sync #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             run_wr_i,
  input  logic             lim_wr_i,
  input  logic             start_i,
  input  logic             ovr_clr_i,
  input  logic             dut_done_i,
  output logic             dut_en_o,
  output logic             busy_o,
  output logic             overrun_o
);

  logic             rst_sync_n;
  logic [CNT_W-1:0] run_len;
  logic [CNT_W-1:0] lim;
  logic             cnt_clr;
  logic             last_run;
  logic             last_lim;
  logic             en;
  logic             busy;

  ccs_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ccs_cfg_regs #(.CNT_W(CNT_W)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .busy_i    (busy),
    .wdata_i   (wdata_i),
    .run_wr_i  (run_wr_i),
    .lim_wr_i  (lim_wr_i),
    .run_len_o (run_len),
    .lim_o     (lim)
  );

  ccs_step_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .clr_i      (cnt_clr),
    .en_i       (en),
    .run_len_i  (run_len),
    .lim_i      (lim),
    .last_run_o (last_run),
    .last_lim_o (last_lim)
  );

  ccs_ctrl_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .start_i    (start_i),
    .ovr_clr_i  (ovr_clr_i),
    .dut_done_i (dut_done_i),
    .run_nz_i   (run_len != '0),
    .last_run_i (last_run),
    .last_lim_i (last_lim),
    .cnt_clr_o  (cnt_clr),
    .dut_en_o   (en),
    .busy_o     (busy),
    .overrun_o  (overrun_o)
  );

  assign dut_en_o = en;
  assign busy_o   = busy;

  // R5: busy window coincides with the enable window
  a_r5_busy_tracks_en: assert property (@(posedge clk) disable iff (!rst_sync_n)
    busy_o == dut_en_o);

endmodule

// File: tb/ccs_step_sync_test.sv
module ccs_step_sync_test;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [W-1:0] wdata;
  logic         run_wr, lim_wr, start, ovr_clr, done;
  logic         dut_en, busy, overrun;

  int n_checks = 0;
  int n_fails  = 0;

  always #5 clk = ~clk;

  ccs_step_sync #(.CNT_W(W)) uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .wdata_i    (wdata),
    .run_wr_i   (run_wr),
    .lim_wr_i   (lim_wr),
    .start_i    (start),
    .ovr_clr_i  (ovr_clr),
    .dut_done_i (done),
    .dut_en_o   (dut_en),
    .busy_o     (busy),
    .overrun_o  (overrun)
  );

  // columns: step length, budget, done on enabled cycle k (0 = never),
  //          expected enabled cycles, expected overrun
  localparam int NV = 10;
  localparam int VEC [NV][5] = '{
    '{5, 0, 0, 5, 0},   // R3 fixed length
    '{1, 0, 0, 1, 0},   // R11 single cycle
    '{0, 0, 3, 3, 0},   // R4 open-ended
    '{0, 0, 1, 1, 0},   // R4 done on first cycle
    '{6, 4, 0, 4, 1},   // R7 fixed length over budget
    '{4, 4, 0, 4, 0},   // R7 exactly on budget
    '{0, 5, 5, 5, 0},   // R7 done on last budget cycle
    '{0, 5, 0, 5, 1},   // R7 open-ended overrun
    '{3, 0, 2, 3, 0},   // R6 done ignored in fixed mode
    '{1, 1, 0, 1, 0}    // R11 with tight budget
  };

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_cfg(input int run_len, input int lim);
    @(negedge clk);
    wdata = W'(run_len); run_wr = 1'b1;
    @(negedge clk);
    run_wr = 1'b0; wdata = W'(lim); lim_wr = 1'b1;
    @(negedge clk);
    lim_wr = 1'b0;
  endtask

  // Pulse start, then count enabled cycles. done_at raises the handshake in
  // that enabled cycle; poke_at fires a start plus a length write in that cycle.
  task automatic run_step(input int done_at, input int poke_at,
                          output int cnt, output int ovr);
    cnt = 0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int guard = 0; guard < 200; guard++) begin
      check("R5 busy vs enable", int'(busy), int'(dut_en));
      if (!dut_en) break;
      cnt++;
      done   = (done_at != 0) && (cnt == done_at);
      start  = (poke_at != 0) && (cnt == poke_at);
      run_wr = start;
      wdata  = W'(2);
      @(negedge clk);
    end
    done = 1'b0; start = 1'b0; run_wr = 1'b0;
    ovr = int'(overrun);
  endtask

  task automatic clear_ovr();
    @(negedge clk);
    ovr_clr = 1'b1;
    @(negedge clk);
    ovr_clr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog (all R): actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

  initial begin
    int c, o;
    rst_n = 1'b0; wdata = '0; run_wr = 1'b0; lim_wr = 1'b0;
    start = 1'b0; ovr_clr = 1'b0; done = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 enable in reset", int'(dut_en), 0);
    check("R1 busy in reset", int'(busy), 0);
    check("R1 overrun in reset", int'(overrun), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 enable after reset", int'(dut_en), 0);
    check("R1 overrun after reset", int'(overrun), 0);

    // R1: registers zero -> open-ended, unlimited; done on cycle 2 ends it
    run_step(2, 0, c, o);
    check("R1 zero length after reset is open-ended", c, 2);

    for (int i = 0; i < NV; i++) begin
      write_cfg(VEC[i][0], VEC[i][1]);
      run_step(VEC[i][2], 0, c, o);
      check($sformatf("R3/R4/R7/R11 vec%0d enabled cycles", i), c, VEC[i][3]);
      check($sformatf("R7 vec%0d overrun", i), o, VEC[i][4]);
      if (o != 0) clear_ovr();
    end

    // R10 and R2: start and length write mid-step are ignored
    write_cfg(8, 0);
    run_step(0, 3, c, o);
    check("R10 start while busy does not stretch step", c, 8);
    run_step(0, 0, c, o);
    check("R2 length write while busy ignored", c, 8);

    // R6: handshake while idle does nothing
    @(negedge clk); done = 1'b1;
    @(negedge clk); done = 1'b0;
    check("R6 done while idle", int'(dut_en), 0);

    // R8: clear with no overrun has no effect
    clear_ovr();
    check("R8 clear while clean", int'(overrun), 0);
    check("R8 clear while clean keeps idle", int'(dut_en), 0);

    // R8/R9: sticky flag and blocked starts
    write_cfg(6, 2);
    run_step(0, 0, c, o);
    check("R7 overrun after budget", o, 1);
    check("R7 budget cycles", c, 2);
    repeat (5) @(negedge clk);
    check("R8 overrun sticky", int'(overrun), 1);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check("R9 start blocked enable", int'(dut_en), 0);
    check("R9 start blocked flag", int'(overrun), 1);
    clear_ovr();
    check("R8 clear drops flag", int'(overrun), 0);
    write_cfg(2, 0);
    run_step(0, 0, c, o);
    check("R8 step after clear", c, 2);

    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

endmodule